// File: doc/BRIEF.md
# Manager-Side Read/Write Hazard Gate

This block sits at the point where a bus manager's internal read and write request queues meet the address channels of an AXI-style interface. It passes each request straight through to its address channel in the same cycle, so traffic moves in both directions at once. It closes the gate only for a request whose byte range collides with something still in flight that it depends on. A read is held while an overlapping write is outstanding. A write is held while an overlapping read is outstanding, or while an overlapping earlier write under another ID is outstanding.

Two separate 4-entry scoreboards record in-flight reads and writes. Each entry holds an ID and the inclusive byte range that the burst covers. A read entry is created when the read address is accepted and retired by the last read-data beat with that ID. A write entry is created when the write address is accepted and retired by the write response with that ID. When several entries share an ID, the oldest one retires first. A per-direction status output reports when a request is being held only because of an overlap.

Top module: `axi_hazard_gate`

## Requirements
- R1: A non-overlapping read request issues on the read address channel while the write address channel is stalled and a write response is pending unaccepted; the read path never waits on write-channel handshakes.
- R2: The read and write scoreboards hold 4 entries each and are independent. With 4 writes outstanding, a further write is held (ready low, hazard status low) while a non-overlapping read still issues. The write issues once entries retire.
- R3: A read whose range overlaps an outstanding write is held until a write response with that write's ID is accepted (b_valid and b_ready both high). It issues in the cycle after that handshake.
- R4: A write whose range overlaps an outstanding read is held until a read-data beat with r_last=1 and that read's ID is accepted. A beat with r_last=0, or a last beat with an ID that matches no outstanding read, does not release it.
- R5: A write overlapping an outstanding write with the same ID issues at once. With a different ID it is held until the earlier write's response is accepted.
- R6: With no overlap and no full scoreboard, a request's valid and its fields appear on the address channel in the same cycle, and the request's ready equals the channel's ready.
- R7: A burst covers bytes addr through addr + (len+1)*2^size - 1 inclusive. Ranges that only touch end to end do not overlap, and a shared single byte counts as overlap.
- R8: A response whose ID matches several entries retires the oldest of them only.
- R9: When a request and the response that retires its conflicting entry arrive in the same cycle, the request stays held in that cycle and issues in the next.
- R10: rd_hazard_stall / wr_hazard_stall are high exactly while a valid request is held by an overlap and its scoreboard is not full. Both are low after reset.
- R11: When an overlapping read and write are presented in the same cycle and the read is accepted, the write is held and then treated as write-after-read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_req_valid | input | 1 | Read request valid |
| rd_req_ready | output | 1 | Read request accepted |
| rd_req_addr | input | ADDR_W | Read start byte address |
| rd_req_len | input | 8 | Read beats minus one |
| rd_req_size | input | 3 | log2 of bytes per read beat |
| rd_req_id | input | ID_W | Read transaction ID |
| wr_req_valid | input | 1 | Write request valid |
| wr_req_ready | output | 1 | Write request accepted |
| wr_req_addr | input | ADDR_W | Write start byte address |
| wr_req_len | input | 8 | Write beats minus one |
| wr_req_size | input | 3 | log2 of bytes per write beat |
| wr_req_id | input | ID_W | Write transaction ID |
| ar_valid | output | 1 | Read address valid |
| ar_ready | input | 1 | Read address ready |
| ar_addr | output | ADDR_W | Read address |
| ar_len | output | 8 | Read burst length |
| ar_size | output | 3 | Read beat size |
| ar_id | output | ID_W | Read ID |
| aw_valid | output | 1 | Write address valid |
| aw_ready | input | 1 | Write address ready |
| aw_addr | output | ADDR_W | Write address |
| aw_len | output | 8 | Write burst length |
| aw_size | output | 3 | Write beat size |
| aw_id | output | ID_W | Write ID |
| r_valid | input | 1 | Read data beat valid (observed) |
| r_ready | input | 1 | Read data beat ready (observed) |
| r_last | input | 1 | Final beat of a read burst |
| r_id | input | ID_W | Read data ID |
| b_valid | input | 1 | Write response valid (observed) |
| b_ready | input | 1 | Write response ready (observed) |
| b_id | input | ID_W | Write response ID |
| rd_hazard_stall | output | 1 | Read held by an overlap |
| wr_hazard_stall | output | 1 | Write held by an overlap |

## Verification
A table of write/read range pairs probes the overlap arithmetic. It covers touching edges, a single shared byte, multi-beat bursts that span from below, and maximum-length bursts at their last byte. Together these separate a correct inclusive end from the usual off-by-one errors. Directed sequences then set each hazard kind against the response that clears it: a non-last beat, a last beat with a foreign ID, same versus different write IDs, and two same-ID entries retired oldest first. The same-cycle release and same-cycle read/write cases show whether a gate opens one cycle early. The full-pool and stalled-write-channel cases show whether capacity or stalls leak from one direction into the other.

// File: rtl/hz_pkg.sv
package hz_pkg;

  localparam int LEN_W  = 8;
  localparam int SIZE_W = 3;
  localparam int SPAN_W = 17;

  typedef logic [LEN_W-1:0]  hz_len_t;
  typedef logic [SIZE_W-1:0] hz_size_t;

  // number of bytes a burst touches: (len+1) << size
  function automatic logic [SPAN_W-1:0] hz_span_bytes(hz_len_t len, hz_size_t size);
    return (SPAN_W'(len) + SPAN_W'(1)) << size;
  endfunction

  // inclusive ranges [alo,ahi] and [blo,bhi] share at least one byte
  function automatic logic hz_overlap(logic [63:0] alo, logic [63:0] ahi,
                                      logic [63:0] blo, logic [63:0] bhi);
    return (alo <= bhi) && (blo <= ahi);
  endfunction

endpackage

// File: rtl/hz_table.sv
module hz_table #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 32,
  parameter int ID_W   = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         alloc_en,
  input  logic [ID_W-1:0]              alloc_id,
  input  logic [ADDR_W-1:0]            alloc_lo,
  input  logic [ADDR_W-1:0]            alloc_hi,
  input  logic                         free_en,
  input  logic [ID_W-1:0]              free_id,
  output logic                         full,
  output logic                         free_hit,
  output logic [DEPTH-1:0]             ent_vld,
  output logic [DEPTH-1:0][ID_W-1:0]   ent_id,
  output logic [DEPTH-1:0][ADDR_W-1:0] ent_lo,
  output logic [DEPTH-1:0][ADDR_W-1:0] ent_hi
);

  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0]             vld_q;
  logic [DEPTH-1:0][ID_W-1:0]   id_q;
  logic [DEPTH-1:0][ADDR_W-1:0] lo_q, hi_q;
  // older_q[i][j] set: entry i was allocated before entry j
  logic [DEPTH-1:0][DEPTH-1:0]  older_q;

  logic [DEPTH-1:0] match_v;
  logic [DEPTH-1:0] retire_v;
  logic [IDX_W-1:0] slot;

  // entries holding the responding ID
  for (genvar i = 0; i < DEPTH; i++) begin : g_match
    assign match_v[i] = free_en && vld_q[i] && (id_q[i] == free_id);
  end

  // pick the oldest of the matching entries
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      retire_v[i] = match_v[i];
      for (int j = 0; j < DEPTH; j++) begin
        if (j != i && match_v[j] && older_q[j][i]) retire_v[i] = 1'b0;
      end
    end
  end

  // lowest free slot for a new entry
  always_comb begin
    slot = '0;
    for (int i = DEPTH-1; i >= 0; i--) begin
      if (!vld_q[i]) slot = IDX_W'(i);
    end
  end

  assign full     = &vld_q;
  assign free_hit = |retire_v;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q   <= '0;
      id_q    <= '0;
      lo_q    <= '0;
      hi_q    <= '0;
      older_q <= '0;
    end else begin
      vld_q <= vld_q & ~retire_v;
      if (alloc_en && !full) begin
        vld_q[slot] <= 1'b1;
        id_q[slot]  <= alloc_id;
        lo_q[slot]  <= alloc_lo;
        hi_q[slot]  <= alloc_hi;
        for (int j = 0; j < DEPTH; j++) begin
          older_q[j][slot] <= vld_q[j];
          older_q[slot][j] <= 1'b0;
        end
      end
    end
  end

  assign ent_vld = vld_q;
  assign ent_id  = id_q;
  assign ent_lo  = lo_q;
  assign ent_hi  = hi_q;

  AST_NO_ALLOC_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |-> !full); // R2
  AST_ONE_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(retire_v)); // R8
  AST_RETIRE_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
    (free_hit && !alloc_en) |=> $countones(vld_q) == $past($countones(vld_q)) - 1); // R3
  AST_ALLOC_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_en && !free_hit) |=> $countones(vld_q) == $past($countones(vld_q)) + 1); // R2

endmodule

// File: rtl/hz_scan.sv
module hz_scan import hz_pkg::*; #(
  parameter int DEPTH    = 4,
  parameter int ADDR_W   = 32,
  parameter int ID_W     = 4,
  parameter bit CHECK_ID = 1'b0
) (
  input  logic [DEPTH-1:0]             ent_vld,
  input  logic [DEPTH-1:0][ID_W-1:0]   ent_id,
  input  logic [DEPTH-1:0][ADDR_W-1:0] ent_lo,
  input  logic [DEPTH-1:0][ADDR_W-1:0] ent_hi,
  input  logic [ADDR_W-1:0]            q_lo,
  input  logic [ADDR_W-1:0]            q_hi,
  input  logic [ID_W-1:0]              q_id,
  output logic                         hit
);

  logic [DEPTH-1:0] hit_v;

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic ovl;
    assign ovl = ent_vld[i] && hz_overlap(64'(ent_lo[i]), 64'(ent_hi[i]), 64'(q_lo), 64'(q_hi));
    if (CHECK_ID) begin : g_idf
      assign hit_v[i] = ovl && (ent_id[i] != q_id);
    end else begin : g_any
      assign hit_v[i] = ovl;
    end
  end

  assign hit = |hit_v;

endmodule

// File: rtl/axi_hazard_gate.sv
module axi_hazard_gate import hz_pkg::*; #(
  parameter int ADDR_W   = 32,
  parameter int ID_W     = 4,
  parameter int RD_DEPTH = 4,
  parameter int WR_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req_valid,
  output logic              rd_req_ready,
  input  logic [ADDR_W-1:0] rd_req_addr,
  input  logic [7:0]        rd_req_len,
  input  logic [2:0]        rd_req_size,
  input  logic [ID_W-1:0]   rd_req_id,
  input  logic              wr_req_valid,
  output logic              wr_req_ready,
  input  logic [ADDR_W-1:0] wr_req_addr,
  input  logic [7:0]        wr_req_len,
  input  logic [2:0]        wr_req_size,
  input  logic [ID_W-1:0]   wr_req_id,
  output logic              ar_valid,
  input  logic              ar_ready,
  output logic [ADDR_W-1:0] ar_addr,
  output logic [7:0]        ar_len,
  output logic [2:0]        ar_size,
  output logic [ID_W-1:0]   ar_id,
  output logic              aw_valid,
  input  logic              aw_ready,
  output logic [ADDR_W-1:0] aw_addr,
  output logic [7:0]        aw_len,
  output logic [2:0]        aw_size,
  output logic [ID_W-1:0]   aw_id,
  input  logic              r_valid,
  input  logic              r_ready,
  input  logic              r_last,
  input  logic [ID_W-1:0]   r_id,
  input  logic              b_valid,
  input  logic              b_ready,
  input  logic [ID_W-1:0]   b_id,
  output logic              rd_hazard_stall,
  output logic              wr_hazard_stall
);

  // request byte ranges (inclusive end)
  logic [ADDR_W-1:0] rq_lo, rq_hi, wq_lo, wq_hi;
  assign rq_lo = rd_req_addr;
  assign rq_hi = rd_req_addr + ADDR_W'(hz_span_bytes(rd_req_len, rd_req_size)) - ADDR_W'(1);
  assign wq_lo = wr_req_addr;
  assign wq_hi = wr_req_addr + ADDR_W'(hz_span_bytes(wr_req_len, wr_req_size)) - ADDR_W'(1);

  // named channel events
  logic rd_fire, wr_fire, rd_done, wr_done;
  assign rd_fire = ar_valid && ar_ready;
  assign wr_fire = aw_valid && aw_ready;
  assign rd_done = r_valid && r_ready && r_last;
  assign wr_done = b_valid && b_ready;

  // scoreboards
  logic                           rt_full, rt_free_hit, wt_full, wt_free_hit;
  logic [RD_DEPTH-1:0]            rt_vld;
  logic [RD_DEPTH-1:0][ID_W-1:0]  rt_id;
  logic [RD_DEPTH-1:0][ADDR_W-1:0] rt_lo, rt_hi;
  logic [WR_DEPTH-1:0]            wt_vld;
  logic [WR_DEPTH-1:0][ID_W-1:0]  wt_id;
  logic [WR_DEPTH-1:0][ADDR_W-1:0] wt_lo, wt_hi;

  hz_table #(.DEPTH(RD_DEPTH), .ADDR_W(ADDR_W), .ID_W(ID_W)) rd_tab_i (
    .clk(clk), .rst_n(rst_n),
    .alloc_en(rd_fire), .alloc_id(rd_req_id), .alloc_lo(rq_lo), .alloc_hi(rq_hi),
    .free_en(rd_done), .free_id(r_id),
    .full(rt_full), .free_hit(rt_free_hit),
    .ent_vld(rt_vld), .ent_id(rt_id), .ent_lo(rt_lo), .ent_hi(rt_hi)
  );

  hz_table #(.DEPTH(WR_DEPTH), .ADDR_W(ADDR_W), .ID_W(ID_W)) wr_tab_i (
    .clk(clk), .rst_n(rst_n),
    .alloc_en(wr_fire), .alloc_id(wr_req_id), .alloc_lo(wq_lo), .alloc_hi(wq_hi),
    .free_en(wr_done), .free_id(b_id),
    .full(wt_full), .free_hit(wt_free_hit),
    .ent_vld(wt_vld), .ent_id(wt_id), .ent_lo(wt_lo), .ent_hi(wt_hi)
  );

  // hazard scans
  logic raw_hit, war_hit, waw_hit, same_cyc_hit;

  hz_scan #(.DEPTH(WR_DEPTH), .ADDR_W(ADDR_W), .ID_W(ID_W), .CHECK_ID(1'b0)) raw_scan_i (
    .ent_vld(wt_vld), .ent_id(wt_id), .ent_lo(wt_lo), .ent_hi(wt_hi),
    .q_lo(rq_lo), .q_hi(rq_hi), .q_id(rd_req_id), .hit(raw_hit)
  );

  hz_scan #(.DEPTH(RD_DEPTH), .ADDR_W(ADDR_W), .ID_W(ID_W), .CHECK_ID(1'b0)) war_scan_i (
    .ent_vld(rt_vld), .ent_id(rt_id), .ent_lo(rt_lo), .ent_hi(rt_hi),
    .q_lo(wq_lo), .q_hi(wq_hi), .q_id(wr_req_id), .hit(war_hit)
  );

  hz_scan #(.DEPTH(WR_DEPTH), .ADDR_W(ADDR_W), .ID_W(ID_W), .CHECK_ID(1'b1)) waw_scan_i (
    .ent_vld(wt_vld), .ent_id(wt_id), .ent_lo(wt_lo), .ent_hi(wt_hi),
    .q_lo(wq_lo), .q_hi(wq_hi), .q_id(wr_req_id), .hit(waw_hit)
  );

  // a read accepted this cycle is older than a write presented alongside it
  assign same_cyc_hit = rd_fire && hz_overlap(64'(rq_lo), 64'(rq_hi), 64'(wq_lo), 64'(wq_hi));

  logic rd_block, wr_block, rd_go, wr_go;
  assign rd_block = raw_hit;
  assign wr_block = war_hit || waw_hit || same_cyc_hit;
  assign rd_go    = !rt_full && !rd_block;
  assign wr_go    = !wt_full && !wr_block;

  assign ar_valid     = rd_req_valid && rd_go;
  assign rd_req_ready = ar_ready && rd_go;
  assign ar_addr      = rd_req_addr;
  assign ar_len       = rd_req_len;
  assign ar_size      = rd_req_size;
  assign ar_id        = rd_req_id;

  assign aw_valid     = wr_req_valid && wr_go;
  assign wr_req_ready = aw_ready && wr_go;
  assign aw_addr      = wr_req_addr;
  assign aw_len       = wr_req_len;
  assign aw_size      = wr_req_size;
  assign aw_id        = wr_req_id;

  assign rd_hazard_stall = rd_req_valid && rd_block && !rt_full;
  assign wr_hazard_stall = wr_req_valid && wr_block && !wt_full;

  AST_AR_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    ar_valid |-> rd_req_valid); // R6
  AST_AW_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    aw_valid |-> wr_req_valid); // R6
  AST_RD_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hazard_stall |-> !ar_valid); // R10
  AST_WR_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hazard_stall |-> !aw_valid); // R10
  AST_RAW_NO_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_done && wt_free_hit && rd_req_valid && raw_hit) |-> !ar_valid); // R9
  AST_WAR_NO_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_done && rt_free_hit && wr_req_valid && war_hit) |-> !aw_valid); // R9
  AST_SAME_CYC_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && wr_req_valid &&
     hz_overlap(64'(rq_lo), 64'(rq_hi), 64'(wq_lo), 64'(wq_hi))) |-> !aw_valid); // R11
  AST_RD_NOT_BY_AW: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rt_full && !raw_hit) |-> ar_valid); // R1

endmodule

// File: tb/axi_hazard_gate_tb_top.sv
module axi_hazard_gate_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        rd_req_valid, rd_req_ready, wr_req_valid, wr_req_ready;
  logic [31:0] rd_req_addr, wr_req_addr, ar_addr, aw_addr;
  logic [7:0]  rd_req_len, wr_req_len, ar_len, aw_len;
  logic [2:0]  rd_req_size, wr_req_size, ar_size, aw_size;
  logic [3:0]  rd_req_id, wr_req_id, ar_id, aw_id, r_id, b_id;
  logic        ar_valid, ar_ready, aw_valid, aw_ready;
  logic        r_valid, r_ready, r_last, b_valid, b_ready;
  logic        rd_hazard_stall, wr_hazard_stall;

  axi_hazard_gate dut_i (
    .clk(clk), .rst_n(rst_n),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
    .rd_req_len(rd_req_len), .rd_req_size(rd_req_size), .rd_req_id(rd_req_id),
    .wr_req_valid(wr_req_valid), .wr_req_ready(wr_req_ready), .wr_req_addr(wr_req_addr),
    .wr_req_len(wr_req_len), .wr_req_size(wr_req_size), .wr_req_id(wr_req_id),
    .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_addr(ar_addr), .ar_len(ar_len),
    .ar_size(ar_size), .ar_id(ar_id),
    .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_addr(aw_addr), .aw_len(aw_len),
    .aw_size(aw_size), .aw_id(aw_id),
    .r_valid(r_valid), .r_ready(r_ready), .r_last(r_last), .r_id(r_id),
    .b_valid(b_valid), .b_ready(b_ready), .b_id(b_id),
    .rd_hazard_stall(rd_hazard_stall), .wr_hazard_stall(wr_hazard_stall)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk + 1, n_bad);
      $finish;
    end
  end

  // overlap table: outstanding write range vs read request range, R7
  typedef struct packed {
    logic [31:0] wa; logic [7:0] wl; logic [2:0] ws;
    logic [31:0] ra; logic [7:0] rl; logic [2:0] rs;
    logic        blk;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{32'h100,  8'd0,   3'd2, 32'h104,  8'd0, 3'd2, 1'b0},
    '{32'h100,  8'd0,   3'd2, 32'h103,  8'd0, 3'd0, 1'b1},
    '{32'h100,  8'd3,   3'd2, 32'h10C,  8'd0, 3'd2, 1'b1},
    '{32'h100,  8'd3,   3'd2, 32'h110,  8'd0, 3'd3, 1'b0},
    '{32'h200,  8'd1,   3'd3, 32'h1F0,  8'd3, 3'd2, 1'b0},
    '{32'h200,  8'd1,   3'd3, 32'h1F0,  8'd4, 3'd2, 1'b1},
    '{32'h1000, 8'd255, 3'd0, 32'h10FF, 8'd0, 3'd0, 1'b1},
    '{32'h1000, 8'd255, 3'd0, 32'h1100, 8'd0, 3'd0, 1'b0}
  };

  task automatic set_rd(input logic v, input logic [31:0] a, input logic [7:0] l,
                        input logic [2:0] s, input logic [3:0] id);
    rd_req_valid = v; rd_req_addr = a; rd_req_len = l; rd_req_size = s; rd_req_id = id;
  endtask

  task automatic set_wr(input logic v, input logic [31:0] a, input logic [7:0] l,
                        input logic [2:0] s, input logic [3:0] id);
    wr_req_valid = v; wr_req_addr = a; wr_req_len = l; wr_req_size = s; wr_req_id = id;
  endtask

  // each task starts and ends at a falling edge
  task automatic issue_wr(input logic [31:0] a, input logic [7:0] l,
                          input logic [2:0] s, input logic [3:0] id);
    set_wr(1'b1, a, l, s, id); aw_ready = 1'b1;
    @(negedge clk);
    wr_req_valid = 1'b0; aw_ready = 1'b0;
  endtask

  task automatic issue_rd(input logic [31:0] a, input logic [7:0] l,
                          input logic [2:0] s, input logic [3:0] id);
    set_rd(1'b1, a, l, s, id); ar_ready = 1'b1;
    @(negedge clk);
    rd_req_valid = 1'b0; ar_ready = 1'b0;
  endtask

  task automatic pulse_b(input logic [3:0] id);
    b_valid = 1'b1; b_id = id;
    @(negedge clk);
    b_valid = 1'b0;
  endtask

  task automatic pulse_r(input logic [3:0] id, input logic last);
    r_valid = 1'b1; r_id = id; r_last = last;
    @(negedge clk);
    r_valid = 1'b0; r_last = 1'b0;
  endtask

  initial begin
    set_rd(1'b0, 32'h0, 8'd0, 3'd0, 4'd0);
    set_wr(1'b0, 32'h0, 8'd0, 3'd0, 4'd0);
    ar_ready = 1'b0; aw_ready = 1'b0;
    r_valid = 1'b0; r_ready = 1'b1; r_last = 1'b0; r_id = 4'd0;
    b_valid = 1'b0; b_ready = 1'b1; b_id = 4'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state, R10
    #2;
    check("R10 reset ar_valid", 32'(ar_valid), 32'd0);
    check("R10 reset aw_valid", 32'(aw_valid), 32'd0);
    check("R10 reset rd_hazard_stall", 32'(rd_hazard_stall), 32'd0);
    check("R10 reset wr_hazard_stall", 32'(wr_hazard_stall), 32'd0);

    // range table walk, R7 / R3 / R6
    foreach (VECS[k]) begin
      issue_wr(VECS[k].wa, VECS[k].wl, VECS[k].ws, 4'd1);
      set_rd(1'b1, VECS[k].ra, VECS[k].rl, VECS[k].rs, 4'd2);
      #2;
      check("R7 range ar_valid", 32'(ar_valid), 32'(!VECS[k].blk));
      check("R7 range rd_hazard_stall", 32'(rd_hazard_stall), 32'(VECS[k].blk));
      rd_req_valid = 1'b0;
      @(negedge clk);
      pulse_b(4'd1);
    end

    // RAW release timing, R3 and R9
    issue_wr(32'h100, 8'd0, 3'd2, 4'd2);
    set_rd(1'b1, 32'h100, 8'd0, 3'd2, 4'd5);
    #2;
    check("R3 read held", 32'(ar_valid), 32'd0);
    b_valid = 1'b1; b_id = 4'd2;
    #2;
    check("R9 read held in release cycle", 32'(ar_valid), 32'd0);
    @(negedge clk);
    b_valid = 1'b0;
    #2;
    check("R3 read issues after B", 32'(ar_valid), 32'd1);
    rd_req_valid = 1'b0;
    @(negedge clk);

    // WAR, R4
    issue_rd(32'h300, 8'd3, 3'd2, 4'd1);
    set_wr(1'b1, 32'h308, 8'd0, 3'd2, 4'd7);
    #2;
    check("R4 write held", 32'(aw_valid), 32'd0);
    check("R10 wr_hazard_stall", 32'(wr_hazard_stall), 32'd1);
    pulse_r(4'd1, 1'b0);
    #2;
    check("R4 non-last beat no release", 32'(aw_valid), 32'd0);
    pulse_r(4'd5, 1'b1);
    #2;
    check("R4 foreign-ID last no release", 32'(aw_valid), 32'd0);
    pulse_r(4'd1, 1'b1);
    #2;
    check("R4 write issues after last beat", 32'(aw_valid), 32'd1);
    wr_req_valid = 1'b0;
    @(negedge clk);

    // WAW, R5
    issue_wr(32'h400, 8'd0, 3'd2, 4'd3);
    set_wr(1'b1, 32'h400, 8'd0, 3'd2, 4'd3);
    #2;
    check("R5 same ID passes", 32'(aw_valid), 32'd1);
    wr_req_id = 4'd4;
    #2;
    check("R5 other ID held", 32'(aw_valid), 32'd0);
    check("R5 other ID stall flag", 32'(wr_hazard_stall), 32'd1);
    pulse_b(4'd3);
    #2;
    check("R5 other ID issues after B", 32'(aw_valid), 32'd1);
    wr_req_valid = 1'b0;
    @(negedge clk);

    // direction independence, R1 / R6
    set_wr(1'b1, 32'hA00, 8'd0, 3'd2, 4'd1);
    aw_ready = 1'b0;
    set_rd(1'b1, 32'h900, 8'd1, 3'd2, 4'd2);
    ar_ready = 1'b1;
    b_ready = 1'b0; b_valid = 1'b1; b_id = 4'd9;
    #2;
    check("R1 read issues under write stall", 32'(ar_valid), 32'd1);
    check("R6 rd_req_ready follows ar_ready", 32'(rd_req_ready), 32'd1);
    check("R6 ar_addr passthrough", ar_addr, 32'h900);
    @(negedge clk);
    rd_req_valid = 1'b0; ar_ready = 1'b0; wr_req_valid = 1'b0;
    b_valid = 1'b0; b_ready = 1'b1;
    pulse_r(4'd2, 1'b1);

    // separate pools, R2
    for (int i = 0; i < 4; i++) issue_wr(32'h1000 + 32'(16 * i), 8'd0, 3'd2, 4'(i));
    set_wr(1'b1, 32'h2000, 8'd0, 3'd2, 4'd9);
    aw_ready = 1'b1;
    set_rd(1'b1, 32'h5000, 8'd0, 3'd2, 4'd1);
    #2;
    check("R2 fifth write not ready", 32'(wr_req_ready), 32'd0);
    check("R2 full is not hazard", 32'(wr_hazard_stall), 32'd0);
    check("R2 read unaffected by full write pool", 32'(ar_valid), 32'd1);
    rd_req_valid = 1'b0; wr_req_valid = 1'b0; aw_ready = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 4; i++) pulse_b(4'(i));
    set_wr(1'b1, 32'h2000, 8'd0, 3'd2, 4'd9);
    #2;
    check("R2 write issues after drain", 32'(aw_valid), 32'd1);
    wr_req_valid = 1'b0;
    @(negedge clk);

    // oldest-first retire, R8
    issue_wr(32'h600, 8'd0, 3'd2, 4'd6);
    issue_wr(32'h700, 8'd0, 3'd2, 4'd6);
    set_rd(1'b1, 32'h700, 8'd0, 3'd2, 4'd1);
    #2;
    check("R8 read of younger held", 32'(ar_valid), 32'd0);
    pulse_b(4'd6);
    #2;
    check("R8 younger still outstanding", 32'(ar_valid), 32'd0);
    rd_req_addr = 32'h600;
    #2;
    check("R8 older entry retired", 32'(ar_valid), 32'd1);
    pulse_b(4'd6);
    rd_req_addr = 32'h700;
    #2;
    check("R8 younger retired by second B", 32'(ar_valid), 32'd1);
    rd_req_valid = 1'b0;
    @(negedge clk);

    // same-cycle read and write, R11
    set_rd(1'b1, 32'h800, 8'd0, 3'd2, 4'd3);
    set_wr(1'b1, 32'h802, 8'd0, 3'd0, 4'd3);
    ar_ready = 1'b1; aw_ready = 1'b1;
    #2;
    check("R11 read wins", 32'(ar_valid), 32'd1);
    check("R11 write held", 32'(aw_valid), 32'd0);
    check("R11 write stall flag", 32'(wr_hazard_stall), 32'd1);
    @(negedge clk);
    rd_req_valid = 1'b0; ar_ready = 1'b0; aw_ready = 1'b0;
    #2;
    check("R11 write held by issued read", 32'(aw_valid), 32'd0);
    pulse_r(4'd3, 1'b1);
    #2;
    check("R11 write issues after read done", 32'(aw_valid), 32'd1);
    wr_req_valid = 1'b0;
    @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule